// File: doc/BRIEF.md
# Page programming controller for a parallel EEPROM

This synchronous controller programs one page of a byte-wide, software-protected parallel EEPROM. A single start request supplies the page number and the number of bytes to load. The controller then opens the part for writing with three fixed command writes. It takes each data byte, together with its offset inside the page, from a valid/ready stream and places it on the memory bus. When the last byte has been loaded, it polls the part until bit 7 reads back as the true value of the last byte written. All strobe timing comes from clock-count parameters.

The memory pins come out as separate address, data-out, data-in and data-drive-enable signals, plus active-low chip enable, output enable and write strobe. The tri-state buffer sits outside the block.

The bytes of one page must arrive before the part's byte-load window closes. If the stream stalls past that window, the controller stops loading and moves to polling. If the stall comes before any data byte has been loaded, it raises its timeout flag instead. A one-cycle done pulse ends a successful program. A one-cycle timeout pulse ends polling that runs past the completion deadline.

States:
- IDLE: waiting for a start request.
- SETUP: strobe high, address and data driven.
- STROBE: strobe low.
- HOLD: strobe risen, address and data still driven.
- WAIT: ready for the next byte.
- GAP: output enable high between polling reads.
- READ: output enable low for a polling read.

Transitions:
- IDLE→SETUP on start.
- SETUP→STROBE when the high phase ends.
- STROBE→HOLD when the low phase ends.
- HOLD→SETUP while command writes remain.
- HOLD→WAIT after the last command write, or after a data byte when more bytes are due.
- HOLD→GAP after the final data byte.
- WAIT→SETUP when a byte is accepted.
- WAIT→GAP when the window expires after at least one data byte.
- WAIT→IDLE when the window expires with no data byte.
- GAP→READ when the gap ends.
- READ→GAP on a mismatch.
- READ→IDLE on a match.
- GAP→IDLE or READ→IDLE when the deadline expires.

Top module: `pgm_page_writer`

## Requirements
- R1: After reset the block is idle. Chip enable, output enable and write strobe are high (inactive). The data drive enable, byte_ready_o, busy_o, done_o and timeout_o are all low.
- R2: The first three write strobes of every burst carry, in this order: address 0x5555 with data 0xAA, then address 0x2AAA with data 0x55, then address 0x5555 with data 0xA0.
- R3: Each accepted stream byte produces exactly one write strobe. Its address is {page, offset}, with the page in address bits 16..7 and the offset in bits 6..0, and its data is the byte. byte_ready_o is raised only in WAIT, and no more bytes are taken once the requested count (1 to 128) has been loaded.
- R4: Every write strobe stays low for exactly LOW_CYC cycles. Between two strobes of one burst it stays high for at least HIGH_CYC+1 cycles. Address and data stay unchanged while the strobe is low and for the first cycle after it rises.
- R5: Output enable is high whenever the write strobe is low. The data drive enable is low whenever output enable is low.
- R6: If no byte arrives within WIN_CYC cycles in WAIT after at least one data byte, loading ends early and polling starts at the last loaded address.
- R7: If the window expires before any data byte has been loaded, timeout_o pulses for one cycle, the block returns to idle, and no polling read is made.
- R8: Polling reads use the address of the last loaded byte. Each read holds output enable low for RD_CYC cycles, and output enable stays high for at least OEH_CYC cycles before each read. One read is made per poll round until completion.
- R9: When a polling read returns bit 7 equal to bit 7 of the last loaded byte, done_o pulses for exactly one cycle and the block returns to idle. done_o and timeout_o are never high together.
- R10: If no matching read occurs within TOUT_CYC cycles of entering polling, timeout_o pulses for one cycle and the block returns to idle without done_o.
- R11: A start request made while busy_o is high is ignored. It launches no further burst and does not alter the page or count of the running one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled only when idle |
| start_page_i | input | 10 | Page number (address bits 16..7) |
| start_count_i | input | 8 | Bytes to load, 1 to 128 (0 means 128) |
| busy_o | output | 1 | High from start until done or timeout |
| byte_valid_i | input | 1 | Stream byte valid |
| byte_ready_o | output | 1 | Controller can take a byte |
| byte_offset_i | input | 7 | Byte offset inside the page |
| byte_data_i | input | 8 | Byte value |
| mem_addr_o | output | 17 | Memory address |
| mem_dq_o | output | 8 | Data driven to the memory |
| mem_dq_i | input | 8 | Data read from the memory |
| mem_dq_oe_o | output | 1 | Drive enable for the data pins |
| mem_ce_n_o | output | 1 | Chip enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_we_n_o | output | 1 | Write strobe, active low |
| done_o | output | 1 | One-cycle pulse on verified completion |
| timeout_o | output | 1 | One-cycle pulse on a missed deadline or an empty burst |

## Verification
The hardest states to reach are the ones that depend on the memory's answer and on stream stalls. The bench therefore models the memory's busy period as a count of polling reads that return the complemented bit 7, so it can choose exactly how many reads precede a match. It also can make that count exceed the deadline.

Early termination is reached by withholding the stream after a chosen number of bytes, or before the first byte. A start request issued in the middle of a burst shows that the controller ignores it.

// File: rtl/pgm_pkg.sv
package pgm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_WAIT,
        ST_GAP,
        ST_READ
    } pgm_state_e;

    localparam int CMD_AW = 15;

    // Unlock command address for step 0..2
    function automatic logic [CMD_AW-1:0] unlock_addr(input logic [1:0] step);
        return (step == 2'd1) ? 15'h2AAA : 15'h5555;
    endfunction

    // Unlock command data for step 0..2
    function automatic logic [7:0] unlock_data(input logic [1:0] step);
        unique case (step)
            2'd0:    return 8'hAA;
            2'd1:    return 8'h55;
            default: return 8'hA0;
        endcase
    endfunction

endpackage

// File: rtl/pgm_phase_timer.sv
module pgm_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic [W-1:0] limit_i,
    output logic         done_o
);
    logic [W-1:0] cnt_q;

    assign done_o = (cnt_q == limit_i - W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clr_i)   cnt_q <= '0;
        else if (!done_o) cnt_q <= cnt_q + W'(1);
    end
endmodule

// File: rtl/pgm_span_counter.sv
module pgm_span_counter #(
    parameter int LIMIT = 100,
    parameter int W     = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic hit_o
);
    logic [W-1:0] cnt_q;

    assign hit_o = (cnt_q == W'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr_i)  cnt_q <= '0;
        else if (!hit_o) cnt_q <= cnt_q + W'(1);
    end

    AST_SPAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= W'(LIMIT - 1)); // R10
endmodule

// File: rtl/pgm_page_writer.sv
module pgm_page_writer
    import pgm_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 8,
    parameter int OFF_W    = 7,
    parameter int HIGH_CYC = 5,
    parameter int LOW_CYC  = 10,
    parameter int OEH_CYC  = 8,
    parameter int RD_CYC   = 10,
    parameter int WIN_CYC  = 7000,
    parameter int TOUT_CYC = 500000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [ADDR_W-OFF_W-1:0]   start_page_i,
    input  logic [OFF_W:0]            start_count_i,
    output logic                      busy_o,
    input  logic                      byte_valid_i,
    output logic                      byte_ready_o,
    input  logic [OFF_W-1:0]          byte_offset_i,
    input  logic [DATA_W-1:0]         byte_data_i,
    output logic [ADDR_W-1:0]         mem_addr_o,
    output logic [DATA_W-1:0]         mem_dq_o,
    input  logic [DATA_W-1:0]         mem_dq_i,
    output logic                      mem_dq_oe_o,
    output logic                      mem_ce_n_o,
    output logic                      mem_oe_n_o,
    output logic                      mem_we_n_o,
    output logic                      done_o,
    output logic                      timeout_o
);
    localparam int PAGE_W     = ADDR_W - OFF_W;
    localparam int CNT_W      = OFF_W + 1;
    localparam int PAGE_BYTES = 1 << OFF_W;
    localparam int MAX_A      = (HIGH_CYC > LOW_CYC) ? HIGH_CYC : LOW_CYC;
    localparam int MAX_B      = (OEH_CYC > RD_CYC) ? OEH_CYC : RD_CYC;
    localparam int PH_MAX     = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int PH_W       = $clog2(PH_MAX + 1);
    localparam logic [1:0] STEP_DATA = 2'd3;

    pgm_state_e        state_q, state_d;
    logic [1:0]        step_q;
    logic [PAGE_W-1:0] page_q;
    logic [CNT_W-1:0]  remain_q;
    logic              loaded_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              done_q, tout_q;

    logic [PH_W-1:0]   ph_lim;
    logic              ph_done, win_hit, dl_hit, polling, match;

    always_comb begin
        unique case (state_q)
            ST_SETUP:  ph_lim = PH_W'(HIGH_CYC);
            ST_STROBE: ph_lim = PH_W'(LOW_CYC);
            ST_GAP:    ph_lim = PH_W'(OEH_CYC);
            ST_READ:   ph_lim = PH_W'(RD_CYC);
            default:   ph_lim = PH_W'(1);
        endcase
    end

    pgm_phase_timer #(.W(PH_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .clr_i(state_d != state_q),
        .limit_i(ph_lim), .done_o(ph_done));

    pgm_span_counter #(.LIMIT(WIN_CYC)) u_window (
        .clk(clk), .rst_n(rst_n), .clr_i(state_q != ST_WAIT), .hit_o(win_hit));

    assign polling = (state_q == ST_GAP) || (state_q == ST_READ);

    pgm_span_counter #(.LIMIT(TOUT_CYC)) u_deadline (
        .clk(clk), .rst_n(rst_n), .clr_i(!polling), .hit_o(dl_hit));

    assign match = (state_q == ST_READ) && ph_done && (mem_dq_i[DATA_W-1] == data_q[DATA_W-1]);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_SETUP;
            ST_SETUP:  if (ph_done) state_d = ST_STROBE;
            ST_STROBE: if (ph_done) state_d = ST_HOLD;
            ST_HOLD: begin
                if (step_q < 2'd2)                           state_d = ST_SETUP;
                else if (step_q == 2'd2)                     state_d = ST_WAIT;
                else if (remain_q == CNT_W'(1))              state_d = ST_GAP;
                else                                         state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (byte_valid_i)  state_d = ST_SETUP;
                else if (win_hit)  state_d = loaded_q ? ST_GAP : ST_IDLE;
            end
            ST_GAP: begin
                if (dl_hit)        state_d = ST_IDLE;
                else if (ph_done)  state_d = ST_READ;
            end
            ST_READ: begin
                if (match || dl_hit) state_d = ST_IDLE;
                else if (ph_done)    state_d = ST_GAP;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            step_q   <= '0;
            page_q   <= '0;
            remain_q <= '0;
            loaded_q <= 1'b0;
            addr_q   <= '0;
            data_q   <= '0;
            done_q   <= 1'b0;
            tout_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= match;
            tout_q  <= ((state_q == ST_WAIT) && !byte_valid_i && win_hit && !loaded_q)
                    || (polling && dl_hit && !match);
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    page_q   <= start_page_i;
                    remain_q <= (start_count_i == '0) ? CNT_W'(PAGE_BYTES) : start_count_i;
                    step_q   <= 2'd0;
                    loaded_q <= 1'b0;
                    addr_q   <= ADDR_W'(unlock_addr(2'd0));
                    data_q   <= DATA_W'(unlock_data(2'd0));
                end
                ST_HOLD: begin
                    if (step_q < 2'd2) begin
                        step_q <= step_q + 2'd1;
                        addr_q <= ADDR_W'(unlock_addr(step_q + 2'd1));
                        data_q <= DATA_W'(unlock_data(step_q + 2'd1));
                    end else if (step_q == 2'd2) begin
                        step_q <= STEP_DATA;
                    end else begin
                        remain_q <= remain_q - CNT_W'(1);
                    end
                end
                ST_WAIT: if (byte_valid_i) begin
                    addr_q   <= {page_q, byte_offset_i};
                    data_q   <= byte_data_i;
                    loaded_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy_o       = (state_q != ST_IDLE);
        byte_ready_o = (state_q == ST_WAIT);
        mem_ce_n_o   = (state_q == ST_IDLE) || (state_q == ST_WAIT);
        mem_we_n_o   = (state_q != ST_STROBE);
        mem_oe_n_o   = (state_q != ST_READ);
        mem_dq_oe_o  = (state_q == ST_SETUP) || (state_q == ST_STROBE) || (state_q == ST_HOLD);
        mem_addr_o   = addr_q;
        mem_dq_o     = data_q;
        done_o       = done_q;
        timeout_o    = tout_q;
    end

    // checker state: length of the current low strobe
    logic [PH_W-1:0] low_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          low_run_q <= '0;
        else if (mem_we_n_o) low_run_q <= '0;
        else                 low_run_q <= low_run_q + PH_W'(1);
    end

    AST_OE_WHILE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n_o |-> mem_oe_n_o); // R5
    AST_DQ_OFF_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n_o |-> !mem_dq_oe_o); // R5
    AST_STROBE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n_o && $past(!mem_we_n_o)) |-> ($stable(mem_addr_o) && $stable(mem_dq_o))); // R4
    AST_RISE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n_o) |-> ($stable(mem_addr_o) && $stable(mem_dq_o) && mem_dq_oe_o)); // R4
    AST_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n_o) |-> (low_run_q == PH_W'(LOW_CYC))); // R4
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && timeout_o)); // R9
    AST_READY_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready_o |-> (mem_we_n_o && !mem_dq_oe_o)); // R3
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9
endmodule

// File: tb/pgm_page_writer_test.sv
module pgm_page_writer_test;
    localparam int HIGH = 3, LOW = 4, OEH = 3, RD = 2, WIN = 20, TOUT = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        start = 1'b0;
    logic [9:0]  page = '0;
    logic [7:0]  count = '0;
    logic        busy, valid = 1'b0, ready;
    logic [6:0]  off = '0;
    logic [7:0]  bdata = '0;
    logic [16:0] maddr;
    logic [7:0]  dq_out, dq_in;
    logic        dq_oe, ce_n, oe_n, we_n, done, tout;

    pgm_page_writer #(.HIGH_CYC(HIGH), .LOW_CYC(LOW), .OEH_CYC(OEH), .RD_CYC(RD),
                      .WIN_CYC(WIN), .TOUT_CYC(TOUT)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .start_page_i(page),
        .start_count_i(count), .busy_o(busy), .byte_valid_i(valid),
        .byte_ready_o(ready), .byte_offset_i(off), .byte_data_i(bdata),
        .mem_addr_o(maddr), .mem_dq_o(dq_out), .mem_dq_i(dq_in),
        .mem_dq_oe_o(dq_oe), .mem_ce_n_o(ce_n), .mem_oe_n_o(oe_n),
        .mem_we_n_o(we_n), .done_o(done), .timeout_o(tout));

    int checks = 0, errors = 0;

    // memory model / monitor state
    logic [16:0] s_addr [16];
    logic [7:0]  s_data [16];
    int          s_low  [16];
    int nstr, low_cnt, hi_cnt, min_gap, stab_viol, oe_viol;
    int nreads, oeh_cnt, min_oeh, done_cyc, tout_cyc, poll_left, rd_len, bad_rd_len;
    logic [16:0] rd_addr, cap_a;
    logic [7:0]  cap_d, last_d;
    logic        prev_oe;

    assign dq_in = (poll_left > 0) ? {~last_d[7], last_d[6:0]} : last_d;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_log(input int polls);
        @(posedge clk);
        nstr = 0; low_cnt = 0; hi_cnt = 0; min_gap = 1000; stab_viol = 0; oe_viol = 0;
        nreads = 0; oeh_cnt = 0; min_oeh = 1000; done_cyc = 0; tout_cyc = 0;
        poll_left = polls; rd_len = 0; bad_rd_len = 0; prev_oe = 1'b1; last_d = '0;
    endtask

    initial clear_log(0);

    always @(negedge clk) begin
        if (rst_n) begin
            if (!we_n) begin
                if (low_cnt == 0) begin
                    cap_a = maddr; cap_d = dq_out;
                    if (nstr > 0 && hi_cnt < min_gap) min_gap = hi_cnt;
                end else if (maddr != cap_a || dq_out != cap_d) stab_viol++;
                if (!oe_n) oe_viol++;
                low_cnt++; hi_cnt = 0;
            end else begin
                if (low_cnt > 0) begin
                    if (nstr < 16) begin
                        s_addr[nstr] = cap_a; s_data[nstr] = cap_d; s_low[nstr] = low_cnt;
                    end
                    last_d = cap_d;
                    nstr++;
                    if (maddr != cap_a || dq_out != cap_d || !dq_oe) stab_viol++;
                    low_cnt = 0;
                end
                hi_cnt++;
            end
            if (!oe_n) begin
                if (prev_oe) begin
                    nreads++; rd_addr = maddr;
                    if (oeh_cnt < min_oeh) min_oeh = oeh_cnt;
                end
                if (dq_oe) oe_viol++;
                rd_len++; oeh_cnt = 0;
            end else begin
                if (!prev_oe) begin
                    if (poll_left > 0) poll_left--;
                    if (rd_len != RD) bad_rd_len++;
                    rd_len = 0;
                end
                oeh_cnt++;
            end
            prev_oe = oe_n;
            if (done) done_cyc++;
            if (tout) tout_cyc++;
        end
    end

    task automatic do_start(input logic [9:0] p, input logic [7:0] c);
        @(negedge clk);
        start = 1'b1; page = p; count = c;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send_byte(input logic [6:0] o, input logic [7:0] d);
        @(negedge clk);
        valid = 1'b1; off = o; bdata = d;
        while (!ready) @(negedge clk);
        @(negedge clk);
        valid = 1'b0;
    endtask

    task automatic wait_end();
        int n = 0;
        while (done_cyc + tout_cyc == 0 && n < 3000) begin
            @(negedge clk); n++;
        end
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(we_n && oe_n && ce_n, "R1 strobes idle in reset", {29'd0, we_n, oe_n, ce_n}, 7);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(we_n && oe_n && ce_n, "R1 strobes idle", {29'd0, we_n, oe_n, ce_n}, 7);
        chk(!dq_oe && !ready && !busy && !done && !tout, "R1 status low",
            {27'd0, dq_oe, ready, busy, done, tout}, 0);
    endtask

    task automatic t_burst();
        clear_log(3);
        do_start(10'h2A5, 8'd4);
        send_byte(7'd5, 8'h3C);
        do_start(10'h011, 8'd1);   // ignored while busy (R11)
        send_byte(7'd1, 8'hC1);
        send_byte(7'd7, 8'h00);
        send_byte(7'd2, 8'h9E);
        wait_end();
        chk(nstr == 7, "R3 strobe count", nstr, 7);
        chk(s_addr[0] == 17'h5555 && s_data[0] == 8'hAA, "R2 first command", s_data[0], 8'hAA);
        chk(s_addr[1] == 17'h2AAA && s_data[1] == 8'h55, "R2 second command", s_data[1], 8'h55);
        chk(s_addr[2] == 17'h5555 && s_data[2] == 8'hA0, "R2 third command", s_data[2], 8'hA0);
        chk(s_addr[3] == {10'h2A5, 7'd5} && s_data[3] == 8'h3C, "R3 byte 0", s_addr[3], {10'h2A5, 7'd5});
        chk(s_addr[4] == {10'h2A5, 7'd1} && s_data[4] == 8'hC1, "R3 R11 byte 1", s_addr[4], {10'h2A5, 7'd1});
        chk(s_addr[6] == {10'h2A5, 7'd2} && s_data[6] == 8'h9E, "R3 byte 3", s_addr[6], {10'h2A5, 7'd2});
        for (int i = 0; i < 7; i++)
            chk(s_low[i] == LOW, "R4 low width", s_low[i], LOW);
        chk(min_gap >= HIGH + 1, "R4 high gap", min_gap, HIGH + 1);
        chk(stab_viol == 0, "R4 addr/data stable", stab_viol, 0);
        chk(oe_viol == 0, "R5 oe/drive exclusion", oe_viol, 0);
        chk(nreads == 4, "R8 read count", nreads, 4);
        chk(rd_addr == {10'h2A5, 7'd2}, "R8 poll address", rd_addr, {10'h2A5, 7'd2});
        chk(min_oeh >= OEH && bad_rd_len == 0, "R8 read timing", min_oeh, OEH);
        chk(done_cyc == 1 && tout_cyc == 0, "R9 done pulse", done_cyc, 1);
        repeat (40) @(negedge clk);
        chk(nstr == 7 && !busy, "R11 no extra burst", nstr, 7);
    endtask

    task automatic t_stall();
        clear_log(2);
        do_start(10'h0F0, 8'd6);
        send_byte(7'd9, 8'hE2);
        send_byte(7'd3, 8'h47);
        wait_end();
        chk(nstr == 5, "R6 early end strobes", nstr, 5);
        chk(nreads == 3 && rd_addr == {10'h0F0, 7'd3}, "R6 poll after stall", nreads, 3);
        chk(done_cyc == 1 && tout_cyc == 0, "R6 R9 done bit7 low", done_cyc, 1);
    endtask

    task automatic t_empty();
        clear_log(0);
        do_start(10'h003, 8'd3);
        wait_end();
        chk(tout_cyc == 1 && done_cyc == 0, "R7 timeout pulse", tout_cyc, 1);
        chk(nstr == 3 && nreads == 0, "R7 no data, no poll", nreads, 0);
        chk(!busy, "R7 back to idle", busy, 0);
    endtask

    task automatic t_deadline();
        clear_log(100000);
        do_start(10'h155, 8'd1);
        send_byte(7'd127, 8'h81);
        wait_end();
        chk(tout_cyc == 1 && done_cyc == 0, "R10 deadline pulse", tout_cyc, 1);
        chk(nreads >= 38 && nreads <= 41, "R10 reads before deadline", nreads, 40);
        chk(!busy, "R10 back to idle", busy, 0);
        poll_left = 0;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_burst();
        t_stall();
        t_empty();
        t_deadline();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule